// File: doc/BRIEF.md
# First-Arrival Four-Channel Latch

This block decides which of several asynchronous request lines went high first, as a contest lockout does. Every line passes through its own synchroniser, and then through an edge detector. The first rising edge seen after reset locks the block. The same clock edge stores the set of lines that rose in that cycle into a result register.

Once the block is locked it ignores all activity on the request lines until the next reset. Any further rise, fall or repeat pulse is locked out, so the result shows only the earliest arrival. If lines rise within the same synchronised cycle, the block keeps all of them together as a tie. Reset is synchronous and active low, and it overrides every input.

Top module: `first_arrival_latch`

## Requirements
- R1: While rst_n is low at a rising clock edge, after that edge both winner and locked are zero, whatever chan_in does.
- R2: After reset, if no line has risen, winner stays 4'b0000 and locked stays 0.
- R3: chan_in is driven just after a clock edge and held. When a line goes from low to high, locked and winner change on the third rising clock edge after that change and not before.
- R4: Bit i of winner corresponds to chan_in[i]. When one line rises alone, winner is the one-hot pattern with only that bit set.
- R5: All lines that rise in the same synchronised cycle are captured together. With every nonzero pattern raised at once, winner equals that pattern.
- R6: If a line rises one clock cycle before another, only the earlier line appears in winner.
- R7: After locked goes high, any rise, fall or repeated pulse on any line leaves winner unchanged.
- R8: locked stays high from the capture until the next reset, and a reset starts a fresh contest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_in | input | 4 | Asynchronous request lines, bit i is channel i |
| winner | output | 4 | Lines captured at the first arrival, zero before it |
| locked | output | 1 | High once a first arrival has been captured |

## Verification
The bench raises every one of the fifteen nonzero patterns at the same instant. Because each result must equal the whole pattern, this shows that ties are captured as a group rather than reduced to one line. It also raises every ordered pair of lines one cycle apart, which separates a real first-arrival decision from simply capturing the input levels. After each capture, the bench toggles the other lines and re-pulses the winning line, to show that later activity cannot reach the result. A separate test checks the exact cycle of capture, and another holds the inputs high during reset to show that reset takes precedence.

// File: rtl/fal_pkg.sv
// Shared definitions for the first-arrival latch.
// Assumes: nothing beyond a synchronous active-low reset in every user.
package fal_pkg;
    // Contest state: open until the first arrival, locked afterwards
    typedef enum logic {
        ST_OPEN   = 1'b0,
        ST_LOCKED = 1'b1
    } contest_state_t;
endpackage

// File: rtl/fal_sync.sv
// Multi-stage synchroniser, one chain per bit.
// Assumes: each din bit is asynchronous and independent; STAGES >= 2.
module fal_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage samples the asynchronous lines
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= din;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            // Later stages resolve metastability
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign dout = stage_q[LAST];
endmodule

// File: rtl/fal_rise_detect.sv
// Per-line rising-edge detector on synchronised levels.
// Assumes: level is already in the clk domain; history resets to low.
module fal_rise_detect #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] prev_q;

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_line
            // Remember last level of this line
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q[i] <= 1'b0;
                else        prev_q[i] <= level[i];
            end
            assign rise[i] = level[i] & ~prev_q[i];
        end
    endgenerate
endmodule

// File: rtl/fal_lock_capture.sv
// Lock flag and result register: the first cycle with any rise locks
// the contest and stores that cycle's rise vector.
// Assumes: rise is a single-cycle pulse per edge.
module fal_lock_capture #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] win,
    output logic             lock
);
    import fal_pkg::*;

    contest_state_t   state_q;
    logic [WIDTH-1:0] win_q;
    logic             arrival;

    assign arrival = |rise;

    // Lock on the first arrival and hold the captured vector until reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OPEN;
            win_q   <= '0;
        end else if (state_q == ST_OPEN && arrival) begin
            state_q <= ST_LOCKED;
            win_q   <= rise;
        end
    end

    assign win  = win_q;
    assign lock = (state_q == ST_LOCKED);
endmodule

// File: rtl/first_arrival_latch.sv
// Top level: synchronise, detect rising edges, lock on the first one.
// Assumes: request pulses last longer than SYNC_STAGES+1 clock periods.
module first_arrival_latch #(
    parameter int N_CH        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] chan_in,
    output logic [N_CH-1:0] winner,
    output logic            locked
);
    logic [N_CH-1:0] sync_lvl;
    logic [N_CH-1:0] rise_vec;

    fal_sync #(.WIDTH(N_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (chan_in),
        .dout  (sync_lvl)
    );

    fal_rise_detect #(.WIDTH(N_CH)) u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .level (sync_lvl),
        .rise  (rise_vec)
    );

    fal_lock_capture #(.WIDTH(N_CH)) u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .rise  (rise_vec),
        .win   (winner),
        .lock  (locked)
    );
endmodule

// File: rtl/fal_checker.sv
// Port-level properties of the first-arrival latch, bound to the top.
module fal_checker #(
    parameter int N_CH = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_CH-1:0] winner,
    input logic            locked
);
    // R1: reset clears both outputs
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!locked && winner == '0));

    // R2: no result without a lock
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> winner == '0);

    // R5: a lock always carries at least one captured line
    a_r5_capture_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> winner != '0);

    // R7: result frozen once locked
    a_r7_win_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(winner));

    // R8: lock is sticky until reset
    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);
endmodule

bind first_arrival_latch fal_checker #(.N_CH(N_CH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .winner (winner),
    .locked (locked)
);

// File: tb/first_arrival_latch_tb.sv
module first_arrival_latch_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] chan_in = 4'b0000;
    logic [3:0] winner;
    logic       locked;
    int         n_chk = 0;
    int         n_fail = 0;

    always #4 clk = ~clk;

    first_arrival_latch u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .chan_in (chan_in),
        .winner  (winner),
        .locked  (locked)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        chan_in = 4'b0000;
        rst_n   = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset state, inputs high during reset
        @(negedge clk);
        chan_in = 4'b1111;
        repeat (4) @(negedge clk);
        chk("R1 winner", winner, 4'b0000);
        chk("R1 locked", {3'b0, locked}, 4'b0000);
        chan_in = 4'b0000;
        @(negedge clk);
        rst_n = 1'b1;
        // R2: idle after reset
        repeat (8) @(negedge clk);
        chk("R2 winner", winner, 4'b0000);
        chk("R2 locked", {3'b0, locked}, 4'b0000);

        // R3: exact capture latency
        do_reset();
        @(negedge clk);
        chan_in = 4'b0100;
        @(posedge clk);
        @(posedge clk);
        #1 chk("R3 not yet", {3'b0, locked}, 4'b0000);
        @(posedge clk);
        #1 chk("R3 locked", {3'b0, locked}, 4'b0001);
        chk("R4 single", winner, 4'b0100);

        // R5: every simultaneous pattern is a tie
        for (int p = 1; p < 16; p++) begin
            do_reset();
            @(negedge clk);
            chan_in = p[3:0];
            repeat (4) @(negedge clk);
            chk("R5 tie", winner, p[3:0]);
            chk("R5 locked", {3'b0, locked}, 4'b0001);
        end

        // R6, R7: ordered pairs, then lockout activity
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                if (a != b) begin
                    do_reset();
                    @(negedge clk);
                    chan_in = 4'b0001 << a;
                    @(negedge clk);
                    chan_in = chan_in | (4'b0001 << b);
                    repeat (4) @(negedge clk);
                    chk("R6 earlier wins", winner, 4'b0001 << a);
                    chan_in = 4'b0000;
                    repeat (4) @(negedge clk);
                    chan_in = ~(4'b0001 << a);
                    repeat (4) @(negedge clk);
                    chan_in = 4'b1111;
                    repeat (4) @(negedge clk);
                    chk("R7 lockout", winner, 4'b0001 << a);
                    chk("R8 sticky", {3'b0, locked}, 4'b0001);
                end
            end
        end

        // R8: reset starts a fresh contest
        do_reset();
        repeat (2) @(negedge clk);
        chk("R8 cleared", {3'b0, locked}, 4'b0000);
        chan_in = 4'b1000;
        repeat (4) @(negedge clk);
        chk("R8 new contest", winner, 4'b1000);

        finish_run();
    end
endmodule